// File: doc/BRIEF.md
# Six-Queue Fixed-Priority Command Arbiter

The arbiter sits between six command queues and a single converter. Each queue presents the command at its head (a command word plus an end-of-group flag). A queue becomes armed either by a software arm pulse or by a rising edge on its hardware trigger line, as chosen by its mode bit. Armed queues that hold a head command compete, and the lowest-numbered one is issued to the converter. The queue stays armed until the command that carries the end-of-group flag has completed.

Queue 0 has a fast path. Its trigger does not wait for the arbiter to go idle. Any conversion in progress is aborted, and the queue 0 command starts a fixed two cycles after the trigger is sampled. An aborted command stays at the head of its queue and is issued again when that queue next wins. When a group of commands is split, the arbiter raises a one-cycle coherency interrupt. A group is split when one of its commands is aborted, or when another queue is granted between two of its commands.

The control state machine has three states:
- `ST_IDLE`: grants the highest-priority eligible queue and moves to `ST_START`.
- `ST_START`: a one-cycle start strobe, then moves to `ST_BUSY`.
- `ST_BUSY`: waits for the converter's done pulse, then pops the head and returns to `ST_IDLE`.

A registered queue 0 fire event overrides all three transitions and enters `ST_START` on queue 0 from any state. When that happens in `ST_START` or `ST_BUSY`, the current conversion is aborted.

Top module: `cmd_arbiter`

## Requirements
- R1: After reset, `conv_start`, `conv_abort`, `coh_irq` and every `cmd_pop` bit are low, and no queue is armed.
- R2: Queue q with `trig_mode[q]`=0 is armed by `sw_arm[q]` high at a clock edge. With `trig_mode[q]`=1 it is armed by `hw_trig[q]` sampled 1 after being sampled 0. The input not selected by the mode has no effect, and a queue that is not armed is never issued.
- R3: When the arbiter is idle and several armed queues hold a head command, the lowest-numbered queue is issued first.
- R4: A queue armed at edge k, with the arbiter idle, gets a one-cycle `conv_start` in the cycle after edge k+1. `conv_qid` carries the queue and `conv_cmd` its head word. The cycle in which `conv_done` is high after the start, `cmd_pop[q]` is high. Completing the end-of-group command disarms the queue.
- R5: A queue 0 trigger sampled at edge k, with queue 0 not armed and its head valid, gives `conv_start` with `conv_qid`=0 in the cycle after edge k+1. This holds whether the arbiter is idle, starting or busy.
- R6: If another queue's conversion is starting or busy when a queue 0 start happens, `conv_abort` is high in the same cycle as that start. The aborted queue gets no `cmd_pop`, even if `conv_done` arrives in the cycle between trigger and start.
- R7: An aborted command is issued again with the same command word once its queue wins arbitration again.
- R8: `coh_irq` pulses together with `conv_start`, with `coh_qid`=q, in two cases. The first is when a command of queue q is aborted. The second is when another queue is granted after queue q completed a command without the end-of-group flag. Each broken group raises it once.
- R9: A group whose commands are issued back to back with no other queue between them raises no `coh_irq`.
- R10: A queue 0 trigger while queue 0 is already armed causes no abort and no extra start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_mode | input | NQ | Per queue: 0 software arm, 1 hardware trigger edge |
| sw_arm | input | NQ | Per-queue software arm pulse |
| hw_trig | input | NQ | Per-queue hardware trigger level |
| cmd_valid | input | NQ | Head command present per queue |
| cmd_word | input | NQ*CW | Head command words, queue q at bits q*CW upward |
| cmd_eog | input | NQ | Head command ends its group |
| cmd_pop | output | NQ | Head of queue consumed |
| conv_start | output | 1 | Converter start strobe |
| conv_abort | output | 1 | Abort of the conversion in progress |
| conv_qid | output | QIW | Queue of the current command |
| conv_cmd | output | CW | Current command word |
| conv_done | input | 1 | Converter finished the current command |
| coh_irq | output | 1 | Coherency interrupt pulse |
| coh_qid | output | QIW | Queue whose group was broken |

## Verification
- **Priority order:** single commands arm three queues in the same cycle. The start order shows whether the lowest index really wins.
- **Coherency:** a three-command group run alone is contrasted with a two-command group interleaved with a higher queue. This separates a coherent group from a split one.
- **Queue 0 fast path:** the queue 0 trigger is applied from idle and from busy. It is also applied with `conv_done` landing in the gap, and again while queue 0 is already armed. These cases show fixed latency, abort with no pop, re-issue of the aborted word, and that a re-trigger is ignored.
- **Trigger modes:** trigger inputs are driven against the wrong mode bit, to show that the input not selected is ignored.

// File: rtl/cmd_arb_pkg.sv
package cmd_arb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_BUSY  = 2'd2
    } arb_state_t;
endpackage

// File: rtl/arb_trigger.sv
module arb_trigger #(
    parameter int NQ = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NQ-1:0] trig_mode,
    input  logic [NQ-1:0] sw_arm,
    input  logic [NQ-1:0] hw_trig,
    output logic [NQ-1:0] arm_evt
);
    logic [NQ-1:0] hw_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) hw_prev <= '0;
        else        hw_prev <= hw_trig;
    end

    for (genvar q = 0; q < NQ; q++) begin : g_q
        // mode picks either the software pulse or a rising hardware edge
        assign arm_evt[q] = trig_mode[q] ? (hw_trig[q] & ~hw_prev[q]) : sw_arm[q];
    end
endmodule

// File: rtl/arb_prio_enc.sv
module arb_prio_enc #(
    parameter int NQ  = 6,
    parameter int QIW = $clog2(NQ)
) (
    input  logic [NQ-1:0]  req,
    output logic           any,
    output logic [QIW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int q = NQ - 1; q >= 0; q--) begin
            if (req[q]) idx = QIW'(q);
        end
    end
endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
    import cmd_arb_pkg::*;
#(
    parameter int NQ  = 6,
    parameter int CW  = 8,
    parameter int QIW = $clog2(NQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NQ-1:0]    arm_evt,
    input  logic [NQ-1:0]    cmd_valid,
    input  logic [NQ*CW-1:0] cmd_word,
    input  logic [NQ-1:0]    cmd_eog,
    input  logic             conv_done,
    input  logic             pick_any,
    input  logic [QIW-1:0]   pick_idx,
    output logic [NQ-1:0]    eligible,
    output logic [NQ-1:0]    cmd_pop,
    output logic             conv_start,
    output logic             conv_abort,
    output logic [QIW-1:0]   conv_qid,
    output logic [CW-1:0]    conv_cmd,
    output logic             coh_irq,
    output logic [QIW-1:0]   coh_qid
);
    arb_state_t     state, state_n;
    logic [QIW-1:0] cur, cur_n;
    logic [NQ-1:0]  armed;
    logic           q0_fire_r;
    logic           abort_r, abort_n;
    logic           irq_r, irq_n;
    logic [QIW-1:0] irqq_r, irqq_n;
    logic           open_vld;
    logic [QIW-1:0] open_q;
    logic [CW-1:0]  cmd_r;
    logic           grant, done_ok, eog_cur;
    logic [NQ-1:0]  disarm;

    assign eligible = armed & cmd_valid;
    assign eog_cur  = cmd_eog[cur];
    assign disarm   = cmd_pop & {NQ{eog_cur}};

    // state register and bookkeeping registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur       <= '0;
            armed     <= '0;
            q0_fire_r <= 1'b0;
            abort_r   <= 1'b0;
            irq_r     <= 1'b0;
            irqq_r    <= '0;
            open_vld  <= 1'b0;
            open_q    <= '0;
            cmd_r     <= '0;
        end else begin
            state     <= state_n;
            cur       <= cur_n;
            armed     <= (armed & ~disarm) | arm_evt;
            q0_fire_r <= arm_evt[0] & ~armed[0] & cmd_valid[0];
            abort_r   <= abort_n;
            irq_r     <= irq_n;
            irqq_r    <= irqq_n;
            if (grant) cmd_r <= cmd_word[cur_n*CW +: CW];
            if (irq_n) begin
                open_vld <= 1'b0;
            end else if (done_ok) begin
                if (eog_cur) begin
                    open_vld <= 1'b0;
                end else begin
                    open_vld <= 1'b1;
                    open_q   <= cur;
                end
            end
        end
    end

    // next-state logic; the queue 0 fire event overrides every transition
    always_comb begin
        state_n = state;
        cur_n   = cur;
        grant   = 1'b0;
        abort_n = 1'b0;
        done_ok = 1'b0;
        if (q0_fire_r) begin
            state_n = ST_START;
            cur_n   = '0;
            grant   = 1'b1;
            abort_n = (state != ST_IDLE);
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (pick_any) begin
                        state_n = ST_START;
                        cur_n   = pick_idx;
                        grant   = 1'b1;
                    end
                end
                ST_START: state_n = ST_BUSY;
                ST_BUSY: begin
                    if (conv_done) begin
                        state_n = ST_IDLE;
                        done_ok = 1'b1;
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
        irq_n  = abort_n | (grant & open_vld & (open_q != cur_n));
        irqq_n = abort_n ? cur : open_q;
    end

    // outputs
    always_comb begin
        conv_start = (state == ST_START);
        conv_abort = abort_r;
        conv_qid   = cur;
        conv_cmd   = cmd_r;
        coh_irq    = irq_r;
        coh_qid    = irqq_r;
        cmd_pop    = done_ok ? (NQ'(1) << cur) : '0;
    end

    assert_start_armed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> armed[conv_qid]);
    assert_pop_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_pop) && !(|cmd_pop && conv_start));
    assert_q0_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q0_fire_r |=> (conv_start && conv_qid == '0));
    assert_abort_with_q0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_abort |-> (conv_start && conv_qid == '0));
    assert_irq_on_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        coh_irq |-> conv_start);
endmodule

// File: rtl/cmd_arbiter.sv
module cmd_arbiter #(
    parameter int NQ  = 6,
    parameter int CW  = 8,
    parameter int QIW = $clog2(NQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NQ-1:0]    trig_mode,
    input  logic [NQ-1:0]    sw_arm,
    input  logic [NQ-1:0]    hw_trig,
    input  logic [NQ-1:0]    cmd_valid,
    input  logic [NQ*CW-1:0] cmd_word,
    input  logic [NQ-1:0]    cmd_eog,
    output logic [NQ-1:0]    cmd_pop,
    output logic             conv_start,
    output logic             conv_abort,
    output logic [QIW-1:0]   conv_qid,
    output logic [CW-1:0]    conv_cmd,
    input  logic             conv_done,
    output logic             coh_irq,
    output logic [QIW-1:0]   coh_qid
);
    logic [NQ-1:0]  arm_evt;
    logic [NQ-1:0]  eligible;
    logic           pick_any;
    logic [QIW-1:0] pick_idx;

    arb_trigger #(.NQ(NQ)) u_trig (
        .clk(clk), .rst_n(rst_n), .trig_mode(trig_mode),
        .sw_arm(sw_arm), .hw_trig(hw_trig), .arm_evt(arm_evt)
    );

    arb_prio_enc #(.NQ(NQ), .QIW(QIW)) u_prio (
        .req(eligible), .any(pick_any), .idx(pick_idx)
    );

    arb_ctrl #(.NQ(NQ), .CW(CW), .QIW(QIW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .arm_evt(arm_evt),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cmd_eog(cmd_eog),
        .conv_done(conv_done), .pick_any(pick_any), .pick_idx(pick_idx),
        .eligible(eligible), .cmd_pop(cmd_pop), .conv_start(conv_start),
        .conv_abort(conv_abort), .conv_qid(conv_qid), .conv_cmd(conv_cmd),
        .coh_irq(coh_irq), .coh_qid(coh_qid)
    );
endmodule

// File: tb/cmd_arbiter_bench.sv
`timescale 1ns/1ps
module cmd_arbiter_bench;
    localparam int NQ = 6;
    localparam int CW = 8;
    localparam int QIW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NQ-1:0] trig_mode = '0, sw_arm = '0, hw_trig = '0;
    logic [NQ-1:0] cmd_valid, cmd_eog, cmd_pop;
    logic [NQ*CW-1:0] cmd_word;
    logic conv_start, conv_abort, conv_done = 1'b0, coh_irq;
    logic [QIW-1:0] conv_qid, coh_qid;
    logic [CW-1:0] conv_cmd;

    int checks = 0, errors = 0, cycles = 0;
    logic [7:0] mw [NQ][16];
    int mcnt [NQ];
    int midx [NQ];

    always #2 clk = ~clk;

    cmd_arbiter u_cmd_arbiter (
        .clk(clk), .rst_n(rst_n), .trig_mode(trig_mode), .sw_arm(sw_arm),
        .hw_trig(hw_trig), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .cmd_eog(cmd_eog), .cmd_pop(cmd_pop), .conv_start(conv_start),
        .conv_abort(conv_abort), .conv_qid(conv_qid), .conv_cmd(conv_cmd),
        .conv_done(conv_done), .coh_irq(coh_irq), .coh_qid(coh_qid)
    );

    // queue heads modelled in the bench
    initial for (int q = 0; q < NQ; q++) begin mcnt[q] = 0; midx[q] = 0; end
    always_comb begin
        for (int q = 0; q < NQ; q++) begin
            cmd_valid[q] = midx[q] < mcnt[q];
            cmd_eog[q]   = (midx[q] == mcnt[q] - 1);
            cmd_word[q*CW +: CW] = (midx[q] < 16) ? mw[q][midx[q]] : 8'h00;
        end
    end
    always @(posedge clk) begin
        for (int q = 0; q < NQ; q++) if (cmd_pop[q]) midx[q] <= midx[q] + 1;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk); #0.5;
    endtask

    task automatic push(input int q, input logic [7:0] w);
        mw[q][mcnt[q]] = w;
        mcnt[q] = mcnt[q] + 1;
    endtask

    task automatic arm(input logic [NQ-1:0] m);
        sw_arm = m; step(); sw_arm = '0;
    endtask

    task automatic wait_start(input string tag, input int q, input int w, input int irq);
        int n = 0;
        while (!conv_start && n < 30) begin step(); n++; end
        chk(conv_start, {tag, " start seen"}, conv_start, 1);
        chk(conv_qid == q, {tag, " qid"}, conv_qid, q);
        chk(conv_cmd == w, {tag, " cmd"}, conv_cmd, w);
        chk(coh_irq == irq, {tag, " coh_irq"}, coh_irq, irq);
    endtask

    task automatic complete(input string tag, input int q);
        step(); conv_done = 1'b1; #0.5;
        chk(cmd_pop == (6'b1 << q), {tag, " pop"}, cmd_pop, 1 << q);
        step(); conv_done = 1'b0;
    endtask

    task automatic quiet(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            step();
            chk(!conv_start && !conv_abort, {tag, " no start"}, conv_start, 0);
        end
    endtask

    task automatic t_reset();
        chk(!conv_start && !conv_abort && !coh_irq && cmd_pop == 0, "R1 reset outputs",
            {conv_start, conv_abort, coh_irq}, 0);
    endtask

    task automatic t_single();
        push(3, 8'h35);
        sw_arm = 6'b001000; step(); sw_arm = '0;
        chk(!conv_start, "R4 no start one cycle after arm", conv_start, 0);
        step();
        wait_start("R4 single", 3, 8'h35, 0);
        complete("R4 single", 3);
        quiet("R4 disarmed after eog", 6);
    endtask

    task automatic t_modes();
        trig_mode = 6'b000100;
        push(2, 8'h22); push(3, 8'h36);
        arm(6'b000100);
        hw_trig[3] = 1'b1;
        quiet("R2 ignored input", 6);
        hw_trig[2] = 1'b1; step();
        chk(!conv_start, "R2 hw edge latency", conv_start, 0);
        step();
        wait_start("R2 hw edge", 2, 8'h22, 0);
        complete("R2 hw edge", 2);
        hw_trig = '0;
        arm(6'b001000);
        wait_start("R2 sw mode", 3, 8'h36, 0);
        complete("R2 sw mode", 3);
        trig_mode = '0;
    endtask

    task automatic t_prio();
        push(4, 8'h41); push(1, 8'h11); push(5, 8'h51);
        arm(6'b110010);
        wait_start("R3 first", 1, 8'h11, 0);  complete("R3 first", 1);
        wait_start("R3 second", 4, 8'h41, 0); complete("R3 second", 4);
        wait_start("R3 third", 5, 8'h51, 0);  complete("R3 third", 5);
    endtask

    task automatic t_group();
        push(2, 8'h2A); push(2, 8'h2B); push(2, 8'h2C);
        arm(6'b000100);
        wait_start("R9 g1", 2, 8'h2A, 0); complete("R9 g1", 2);
        wait_start("R9 g2", 2, 8'h2B, 0); complete("R9 g2", 2);
        wait_start("R9 g3", 2, 8'h2C, 0); complete("R9 g3", 2);
        quiet("R9 group done", 4);
    endtask

    task automatic t_split();
        push(3, 8'h3A); push(3, 8'h3B); push(1, 8'h1A);
        arm(6'b001000);
        wait_start("R8 split first", 3, 8'h3A, 0);
        step(); sw_arm = 6'b000010;
        step(); sw_arm = '0; conv_done = 1'b1; #0.5;
        chk(cmd_pop == 6'b001000, "R8 pop first", cmd_pop, 8);
        step(); conv_done = 1'b0;
        wait_start("R8 interloper", 1, 8'h1A, 1);
        chk(coh_qid == 3, "R8 coh_qid split", coh_qid, 3);
        complete("R8 interloper", 1);
        wait_start("R8 split rest", 3, 8'h3B, 0);
        complete("R8 split rest", 3);
    endtask

    task automatic t_abort(input bit collide);
        int q = collide ? 5 : 4;
        logic [7:0] w = collide ? 8'h5A : 8'h4A;
        push(q, w); push(0, collide ? 8'h0B : 8'h0A);
        arm(6'b1 << q);
        wait_start("R6 victim", q, w, 0);
        step(); sw_arm = 6'b000001;
        step(); sw_arm = '0;
        if (collide) conv_done = 1'b1;
        #0.5;
        chk(!conv_start, "R5 busy trigger latency", conv_start, 0);
        chk(cmd_pop == 0, "R6 no pop of aborted", cmd_pop, 0);
        step(); conv_done = 1'b0;
        chk(conv_start && conv_qid == 0, "R5 q0 start after two cycles", conv_qid, 0);
        chk(conv_abort, "R6 abort pulse", conv_abort, 1);
        chk(coh_irq && coh_qid == q, "R8 irq on abort", coh_qid, q);
        chk(conv_cmd == (collide ? 8'h0B : 8'h0A), "R5 q0 cmd", conv_cmd, collide ? 8'h0B : 8'h0A);
        complete("R5 q0", 0);
        wait_start("R7 reissue", q, w, 0);
        chk(!conv_abort, "R7 reissue no abort", conv_abort, 0);
        complete("R7 reissue", q);
    endtask

    task automatic t_q0_idle();
        push(0, 8'h0C); push(0, 8'h0D);
        sw_arm = 6'b000001; step(); sw_arm = '0;
        chk(!conv_start, "R5 idle latency", conv_start, 0);
        step();
        chk(conv_start && conv_qid == 0 && !conv_abort, "R5 idle q0 start", conv_qid, 0);
        step(); sw_arm = 6'b000001;
        step(); sw_arm = '0;
        chk(!conv_start && !conv_abort, "R10 retrigger ignored a", conv_abort, 0);
        step();
        chk(!conv_start && !conv_abort, "R10 retrigger ignored b", conv_abort, 0);
        conv_done = 1'b1; #0.5;
        chk(cmd_pop == 6'b000001, "R10 pop q0", cmd_pop, 1);
        step(); conv_done = 1'b0;
        wait_start("R10 q0 second", 0, 8'h0D, 0);
        complete("R10 q0 second", 0);
        quiet("R10 q0 drained", 5);
    endtask

    initial begin
        repeat (3) step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_single();
        t_modes();
        t_prio();
        t_group();
        t_split();
        t_abort(1'b0);
        t_abort(1'b1);
        t_q0_idle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule